// File: doc/BRIEF.md
# Raster Position Latch on Strobe

This block records where a character-cell display controller is in its frame at the moment an external strobe pin falls. The controller's running character-column counter and character-row counter come in from outside. On each high-to-low transition of the strobe, both counters are copied into a pair of holding registers. A host register port reads those registers back. The strobe may be driven by a light-sensing pen, or by software toggling a general-purpose port bit to take a timing reference.

The counters outside this block advance once per character cell. The character cell's width and height are programmed elsewhere, so the captured values are coarse in proportion to those cell sizes. The strobe is asynchronous, so it passes through a two-flop synchronizer, and the edge is detected in the controller clock domain. The strobe may fire any number of times within one frame. Each new fall replaces the previous pair of values. A flag tells the host that a fresh capture exists. Reading the column register clears that flag.

Top module: `raster_pos_latch`

## Requirements
- R1: During and right after a synchronous active-low reset, both latches read zero and the capture flag `cap_valid` is low.
- R2: When `strobe_n` falls between two rising clock edges, the values on `hpos_i` and `vpos_i` at the third rising edge after the fall are captured. Before that edge, the latches still show the earlier values.
- R3: A low-to-high transition of `strobe_n` captures nothing. The latches and the flag keep their values.
- R4: While `strobe_n` holds steady, the latches keep their contents while the counters keep moving.
- R5: Each further falling edge in the same frame overwrites both latches with the new counter values.
- R6: A capture sets `cap_valid` at the same rising edge that loads the latches.
- R7: A host read with `rd_en`=1 and `rd_sel`=0 (column register) clears `cap_valid` at the next edge. A read with `rd_sel`=1 (row register) leaves the flag unchanged.
- R8: When a column-register read and a capture meet at the same edge, the capture wins: `cap_valid` stays high and the latches take the new values.
- R9: `rd_data` shows the column latch, zero-extended, when `rd_sel`=0, and the row latch, zero-extended, when `rd_sel`=1. It is valid combinationally, whatever `rd_en` is.
- R10: The row latch returns exactly the row count present at capture, including a value of 1 taken right after vertical blanking starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strobe_n | input | 1 | Asynchronous capture strobe, falling edge active |
| hpos_i | input | HPOS_W (8) | Running character-column counter |
| vpos_i | input | VPOS_W (6) | Running character-row counter |
| rd_en | input | 1 | Host read strobe |
| rd_sel | input | 1 | Register select: 0 column, 1 row |
| rd_data | output | max(HPOS_W,VPOS_W) | Selected latch, zero-extended |
| lat_h | output | HPOS_W | Column latch |
| lat_v | output | VPOS_W | Row latch |
| cap_valid | output | 1 | Capture seen since the last column read |

## Verification
The bench changes the counters every cycle around a strobe fall. An off-by-one in synchronizer depth or edge detection would therefore latch a neighbouring value, and a design that captured too early would show the new value one cycle early. A rising strobe edge with moving counters catches a design that triggers on both edges or on level. A column read is placed on exactly the capture edge: a design that gave priority to the read would drop the flag. A row-only read checks that the flag is cleared only by the column register.

// File: rtl/posl_pkg.sv
// Shared parameters and types for the raster position latch.
// Assumes the consumers pick widths no larger than a few dozen bits.
package posl_pkg;
    localparam int POSL_HPOS_W = 8;
    localparam int POSL_VPOS_W = 6;
    localparam int POSL_SYNC_STAGES = 2;

    typedef enum logic {
        SEL_COLUMN = 1'b0,
        SEL_ROW    = 1'b1
    } posl_sel_e;
endpackage

// File: rtl/posl_sync.sv
// Multi-flop synchronizer for a single asynchronous level.
// Resets to RST_VAL so that an idle-high strobe gives no false edge at reset release.
module posl_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the raw level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
        end
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/posl_fall_det.sv
// Produces a one-cycle pulse when a synchronous level goes from 1 to 0.
// Assumes the input is already in the clk domain.
module posl_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic fall_o
);
    logic prev_q;

    // Remember the level from the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
        end else begin
            prev_q <= level_i;
        end
    end

    assign fall_o = prev_q & ~level_i;
endmodule

// File: rtl/posl_capture.sv
// Holds the captured column/row counts and the fresh-capture flag.
// A capture has priority over a flag-clearing read in the same cycle.
module posl_capture #(
    parameter int HPOS_W = 8,
    parameter int VPOS_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_stb,
    input  logic              clr_req,
    input  logic [HPOS_W-1:0] hpos_i,
    input  logic [VPOS_W-1:0] vpos_i,
    output logic [HPOS_W-1:0] lat_h,
    output logic [VPOS_W-1:0] lat_v,
    output logic              cap_valid
);
    // Load both position latches on a capture pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_h <= '0;
            lat_v <= '0;
        end else if (cap_stb) begin
            lat_h <= hpos_i;
            lat_v <= vpos_i;
        end
    end

    // Set on capture, clear on column read, capture first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_valid <= 1'b0;
        end else if (cap_stb) begin
            cap_valid <= 1'b1;
        end else if (clr_req) begin
            cap_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/raster_pos_latch.sv
// Top of the raster position latch: synchronizes the strobe, finds its
// falling edge, captures the character counters and serves host reads.
// Assumes the counters are synchronous to clk and advance once per cell.
module raster_pos_latch
    import posl_pkg::*;
#(
    parameter int HPOS_W      = POSL_HPOS_W,
    parameter int VPOS_W      = POSL_VPOS_W,
    parameter int SYNC_STAGES = POSL_SYNC_STAGES,
    localparam int DATA_W     = (HPOS_W > VPOS_W) ? HPOS_W : VPOS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_n,
    input  logic [HPOS_W-1:0] hpos_i,
    input  logic [VPOS_W-1:0] vpos_i,
    input  logic              rd_en,
    input  logic              rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic [HPOS_W-1:0] lat_h,
    output logic [VPOS_W-1:0] lat_v,
    output logic              cap_valid
);
    logic strobe_sync;
    logic cap_stb;
    logic clr_req;

    posl_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (strobe_n),
        .sync_o  (strobe_sync)
    );

    posl_fall_det fall_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (strobe_sync),
        .fall_o  (cap_stb)
    );

    assign clr_req = rd_en && (rd_sel == SEL_COLUMN);

    posl_capture #(
        .HPOS_W (HPOS_W),
        .VPOS_W (VPOS_W)
    ) cap_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_stb   (cap_stb),
        .clr_req   (clr_req),
        .hpos_i    (hpos_i),
        .vpos_i    (vpos_i),
        .lat_h     (lat_h),
        .lat_v     (lat_v),
        .cap_valid (cap_valid)
    );

    // Read mux: selected latch, zero-extended.
    always_comb begin
        rd_data = '0;
        if (rd_sel == SEL_ROW) begin
            rd_data[VPOS_W-1:0] = lat_v;
        end else begin
            rd_data[HPOS_W-1:0] = lat_h;
        end
    end
endmodule

// File: rtl/posl_checker.sv
// Temporal checks for the raster position latch, bound to the top module.
// Observes the internal capture pulse alongside the ports.
module posl_checker #(
    parameter int HPOS_W = 8,
    parameter int VPOS_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cap_stb,
    input logic              rd_en,
    input logic              rd_sel,
    input logic [HPOS_W-1:0] hpos_i,
    input logic [VPOS_W-1:0] vpos_i,
    input logic [HPOS_W-1:0] lat_h,
    input logic [VPOS_W-1:0] lat_v,
    input logic              cap_valid
);
    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (lat_h == '0 && lat_v == '0 && !cap_valid)); // R1
    AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cap_stb |=> (lat_h == $past(hpos_i) && lat_v == $past(vpos_i))); // R2
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_stb |=> ($stable(lat_h) && $stable(lat_v))); // R4
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n) cap_stb |=> cap_valid); // R6
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_sel && !cap_stb) |=> !cap_valid); // R7
    AST_ROW_READ_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_sel && cap_valid) |=> cap_valid); // R7
    AST_CAPTURE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_sel && cap_stb) |=> cap_valid); // R8
endmodule

bind raster_pos_latch posl_checker #(
    .HPOS_W (HPOS_W),
    .VPOS_W (VPOS_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_stb   (cap_stb),
    .rd_en     (rd_en),
    .rd_sel    (rd_sel),
    .hpos_i    (hpos_i),
    .vpos_i    (vpos_i),
    .lat_h     (lat_h),
    .lat_v     (lat_v),
    .cap_valid (cap_valid)
);

// File: tb/raster_pos_latch_tb_top.sv
module raster_pos_latch_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strobe_n = 1'b1;
    logic [7:0] hpos_i = '0;
    logic [5:0] vpos_i = '0;
    logic       rd_en = 1'b0;
    logic       rd_sel = 1'b0;
    logic [7:0] rd_data;
    logic [7:0] lat_h;
    logic [5:0] lat_v;
    logic       cap_valid;
    int n_checks = 0;
    int n_fails = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    raster_pos_latch dut_i (
        .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n),
        .hpos_i(hpos_i), .vpos_i(vpos_i), .rd_en(rd_en), .rd_sel(rd_sel),
        .rd_data(rd_data), .lat_h(lat_h), .lat_v(lat_v), .cap_valid(cap_valid)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Falls the strobe at a negedge and moves the counters each half-period after.
    // Values a..d are presented in turn; c sits on the third rising edge.
    task automatic fall_seq(input int a, input int b, input int c, input int d,
                            input int vr, input logic rd_at_cap);
        @(negedge clk); strobe_n = 1'b0; hpos_i = 8'(a); vpos_i = 6'(vr + 1);
        @(negedge clk); hpos_i = 8'(b); vpos_i = 6'(vr + 2);
        @(negedge clk); hpos_i = 8'(c); vpos_i = 6'(vr);
        if (rd_at_cap) begin rd_en = 1'b1; rd_sel = 1'b0; end
        @(negedge clk); hpos_i = 8'(d); vpos_i = 6'(vr + 3); rd_en = 1'b0;
    endtask

    task automatic rise_strobe();
        @(negedge clk); strobe_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 lat_h", lat_h, 0);
        check("R1 lat_v", lat_v, 0);
        check("R1 cap_valid", cap_valid, 0);
        check("R1 rd_data", rd_data, 0);
    endtask

    task automatic t_latency();
        @(negedge clk); strobe_n = 1'b0; hpos_i = 8'd10; vpos_i = 6'd3;
        @(negedge clk); hpos_i = 8'd11;
        check("R2 not yet after one edge", lat_h, 0);
        @(negedge clk); hpos_i = 8'd12; vpos_i = 6'd4;
        check("R2 not yet after two edges", lat_h, 0);
        check("R6 flag not yet", cap_valid, 0);
        @(negedge clk); hpos_i = 8'd13; vpos_i = 6'd5;
        check("R2 column captured at third edge", lat_h, 12);
        check("R2 row captured at third edge", lat_v, 4);
        check("R6 flag set", cap_valid, 1);
    endtask

    task automatic t_hold_and_rise();
        repeat (4) begin @(negedge clk); hpos_i = hpos_i + 8'd7; vpos_i = vpos_i + 6'd1; end
        check("R4 column held while low", lat_h, 12);
        check("R4 row held while low", lat_v, 4);
        @(negedge clk); strobe_n = 1'b1;
        repeat (5) begin @(negedge clk); hpos_i = hpos_i + 8'd3; end
        check("R3 rise leaves column", lat_h, 12);
        check("R3 rise leaves row", lat_v, 4);
    endtask

    task automatic t_reads();
        @(negedge clk); rd_sel = 1'b1;
        #1 check("R9 row mux", rd_data, 4);
        rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        check("R7 row read keeps flag", cap_valid, 1);
        rd_sel = 1'b0;
        #1 check("R9 column mux", rd_data, 12);
        rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        check("R7 column read clears flag", cap_valid, 0);
    endtask

    task automatic t_retrigger();
        fall_seq(40, 41, 42, 43, 9, 1'b0);
        check("R5 first of frame column", lat_h, 42);
        rise_strobe();
        fall_seq(70, 71, 72, 73, 17, 1'b0);
        check("R5 overwrite column", lat_h, 72);
        check("R5 overwrite row", lat_v, 17);
        rise_strobe();
    endtask

    task automatic t_collision();
        fall_seq(100, 101, 102, 103, 20, 1'b1);
        check("R8 flag survives same-cycle read", cap_valid, 1);
        check("R8 column loaded", lat_h, 102);
        rise_strobe();
    endtask

    task automatic t_vblank_row();
        fall_seq(2, 3, 5, 6, 1, 1'b0);
        check("R10 row reads one", lat_v, 1);
        rd_sel = 1'b1;
        #1 check("R10 row via port", rd_data, 1);
        rd_sel = 1'b0;
        rise_strobe();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latency();
        t_hold_and_rise();
        t_reads();
        t_retrigger();
        t_collision();
        t_vblank_row();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 5000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule